// File: doc/BRIEF.md
# SDRAM Init and Command Sequencer

This block owns the command pins of a single SDRAM device. After reset it stays busy and waits for a start pulse. It then brings the device up with a precharge of all banks, a train of eight auto-refresh commands and a mode-register load that selects burst length 4 and CAS latency 2. Only after that load does it open for traffic.

Once open, it accepts one request at a time, either a read or a write of one four-beat burst. Each request runs through row activate, column command and precharge-all, with fixed gaps between the commands. A tick input feeds an internal refresh timer. Every sixteenth tick raises a refresh request, which is served between accesses and never in the middle of one.

The command is presented as `{cs_n, ras_n, cas_n, we_n}`. Two strobes mark the cycles in which the read data bus holds valid data and the cycles in which the write data bus must be driven.

Top module: `sdram_cmd_seq`

## Requirements
- R1: From reset and until initialization ends, `busy_o` is high, `init_done_o` is low and no request is accepted, even if `req_valid_i` is held high. In reset the command is NOP.
- R2: A `start_i` pulse sampled before initialization gives a precharge-all command, with `addr_o[10]` = 1, in the following cycle. A `start_i` pulse sampled after initialization has no effect.
- R3: The first init refresh comes 3 cycles after the init precharge. Eight refresh commands are then issued in eight consecutive cycles.
- R4: After the last init refresh there are 7 NOP cycles, then a mode-register load with `addr_o` = 0x022 (burst length 4 coded 3'b010 in bits [2:0], CAS latency 2 in bits [6:4]).
- R5: In the cycle after the mode load, `init_done_o` rises and `busy_o` falls. Refresh ticks that arrive before that cycle are not counted.
- R6: A request is accepted at a clock edge where `req_valid_i` is high and `busy_o` is low. The address is split {bank, row, col} = {[19], [18:8], [7:0]}. In the next cycle the command is ACT with the row on `addr_o`, the bank on `ba_o`, and `busy_o` high.
- R7: The read or write command follows 2 cycles after ACT. It carries the column in `addr_o[7:0]`, and all other address bits are 0 (`addr_o[10]` = 0).
- R8: After a read command, `rd_valid_o` is high for exactly the 4 cycles that start 2 cycles after the command.
- R9: After a read, precharge-all comes 6 cycles after the read command, which is 1 cycle after the last data beat.
- R10: After a write command, `wr_en_o` is high in that cycle and the 3 cycles that follow. Precharge-all comes 5 cycles after the write command, leaving one recovery cycle after the last beat.
- R11: After an access precharge, `busy_o` stays high for 1 more cycle and falls 2 cycles after it. The next ACT or refresh can therefore come no earlier than 3 cycles after the precharge.
- R12: After initialization, the 16th refresh tick raises a pending refresh, and `busy_o` is high from the next cycle. A pending refresh is issued from idle. If an access is running, the refresh waits and is issued 3 cycles after that access's precharge.
- R13: A periodic refresh keeps `busy_o` high for the 6 cycles after it, so the next command comes no earlier than 8 cycles after the refresh. A pending refresh is served before a waiting request.
- R14: Command codes `{cs_n,ras_n,cas_n,we_n}` are: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE LOAD 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the power-up sequence |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | {bank, row, col} request address |
| ref_tick_i | input | 1 | Refresh timer tick |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr_o | output | 11 | SDRAM address pins |
| ba_o | output | 1 | Bank address |
| busy_o | output | 1 | High when a request would not be accepted |
| init_done_o | output | 1 | Initialization complete |
| rd_valid_o | output | 1 | Read data valid on the data bus |
| wr_en_o | output | 1 | Write data must be driven |

## Verification
The in-RTL assertions check these on every cycle:
- the 3-cycle gap from precharge to activate;
- the 2-cycle gap from activate to column command;
- the 7-cycle quiet time after a refresh before an activate or mode load;
- that no access command appears before initialization, and that busy holds during initialization;
- that read-valid only ever rises two cycles after a read command;
- that a pending refresh only ever appears after a tick.

Only the bench scenarios show the rest:
- the exact order of the power-up sequence and the mode-register value;
- the precharge offsets for reads and writes;
- that the tick count starts only after initialization;
- the arbitration cases: a refresh that comes due during an access waits for that access, and it then goes ahead of a request that is already waiting.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_IPRE, ST_IREF, ST_MRS, ST_IDLE, ST_REF,
    ST_ACT, ST_RD, ST_WR, ST_PRE, ST_WAIT
  } state_e;

  // fixed device timing, in clocks
  localparam int unsigned T_RP       = 3;   // precharge to next command
  localparam int unsigned T_RCD      = 2;   // activate to column command
  localparam int unsigned CAS_LAT    = 2;
  localparam int unsigned BURST_LEN  = 4;
  localparam int unsigned T_RDL      = 1;   // last read beat to precharge
  localparam int unsigned T_WR       = 1;   // idle cycles after last write beat
  localparam int unsigned T_RFC_GAP  = 7;   // NOP cycles after a refresh
  localparam int unsigned INIT_REFS  = 8;
  localparam int unsigned REF_RELOAD = 16;
  localparam int unsigned AP_BIT     = 10;  // precharge-all / auto-precharge pin

  localparam int unsigned RD_TO_PRE = CAS_LAT + BURST_LEN - 1 + T_RDL;
  localparam int unsigned WR_TO_PRE = BURST_LEN - 1 + T_WR + 1;
  localparam logic [2:0]  MR_BL     = 3'($clog2(BURST_LEN));
  localparam logic [2:0]  MR_CL     = 3'(CAS_LAT);

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned RELOAD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int unsigned CNT_W = $clog2(RELOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             expire;

  assign expire = en_i && tick_i && (cnt_q == '0);
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(RELOAD - 1);
      pend_q <= 1'b0;
    end else begin
      if (en_i && tick_i)
        cnt_q <= (cnt_q == '0) ? CNT_W'(RELOAD - 1) : cnt_q - 1'b1;
      pend_q <= (pend_q && !take_i) || expire;
    end
  end

  assert_pend_after_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(tick_i && en_i));

endmodule

// File: rtl/sdram_data_timer.sv
module sdram_data_timer #(
  parameter int unsigned CL = 2,
  parameter int unsigned BL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  input  logic wr_issue_i,
  output logic rd_valid_o,
  output logic wr_en_o
);
  localparam int unsigned CNT_W = $clog2(BL);

  logic [CL-1:0]    rd_dly_q;
  logic [CNT_W-1:0] rd_cnt_q, wr_cnt_q;
  logic             rd_first;

  generate
    if (CL == 1) begin : g_cl1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rd_dly_q <= '0;
        else         rd_dly_q <= rd_issue_i;
    end else begin : g_cln
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rd_dly_q <= '0;
        else         rd_dly_q <= {rd_dly_q[CL-2:0], rd_issue_i};
    end
  endgenerate

  assign rd_first   = rd_dly_q[CL-1];
  assign rd_valid_o = rd_first || (rd_cnt_q != '0);
  assign wr_en_o    = wr_issue_i || (wr_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
    end else begin
      if (rd_first)            rd_cnt_q <= CNT_W'(BL - 1);
      else if (rd_cnt_q != '0) rd_cnt_q <= rd_cnt_q - 1'b1;
      if (wr_issue_i)          wr_cnt_q <= CNT_W'(BL - 1);
      else if (wr_cnt_q != '0) wr_cnt_q <= wr_cnt_q - 1'b1;
    end
  end

  assert_rd_valid_cas_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(rd_issue_i, 2));

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              ref_pend_i,
  output logic              ref_take_o,
  output logic              init_done_o,
  output logic              busy_o,
  output cmd_e              cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              rd_issue_o,
  output logic              wr_issue_o
);
  localparam int unsigned WCNT_W = 4;
  localparam int unsigned IREF_W = $clog2(INIT_REFS);
  localparam logic [WCNT_W-1:0] W_IPRE = WCNT_W'(T_RP - 2);
  localparam logic [WCNT_W-1:0] W_IREF = WCNT_W'(T_RFC_GAP - 1);
  localparam logic [WCNT_W-1:0] W_REF  = WCNT_W'(T_RFC_GAP - 2);
  localparam logic [WCNT_W-1:0] W_ACT  = WCNT_W'(T_RCD - 2);
  localparam logic [WCNT_W-1:0] W_RD   = WCNT_W'(RD_TO_PRE - 2);
  localparam logic [WCNT_W-1:0] W_WR   = WCNT_W'(WR_TO_PRE - 2);
  localparam logic [WCNT_W-1:0] W_PRE  = WCNT_W'(T_RP - 3);
  localparam logic [ROW_W-1:0]  MODE_WORD = ROW_W'({MR_CL, 1'b0, MR_BL});
  localparam logic [ROW_W-1:0]  AP_MASK   = ROW_W'(1) << AP_BIT;

  state_e              state_q, state_d, ret_q, ret_d;
  logic [WCNT_W-1:0]   wcnt_q, wcnt_d;
  logic [IREF_W-1:0]   iref_q, iref_d;
  logic                done_q;
  logic                lat_we_q;
  logic [BANK_W-1:0]   lat_bank_q;
  logic [ROW_W-1:0]    lat_row_q;
  logic [COL_W-1:0]    lat_col_q;
  logic                accept;

  assign accept      = (state_q == ST_IDLE) && !ref_pend_i && req_valid_i;
  assign ref_take_o  = (state_q == ST_IDLE) && ref_pend_i;
  assign busy_o      = (state_q != ST_IDLE) || ref_pend_i;
  assign init_done_o = done_q;
  assign rd_issue_o  = (state_q == ST_RD);
  assign wr_issue_o  = (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    wcnt_d  = wcnt_q;
    iref_d  = iref_q;
    unique case (state_q)
      ST_OFF:  if (start_i) state_d = ST_IPRE;
      ST_IPRE: begin
        state_d = ST_WAIT; wcnt_d = W_IPRE; ret_d = ST_IREF; iref_d = '0;
      end
      ST_IREF: begin
        iref_d = iref_q + 1'b1;
        if (iref_q == IREF_W'(INIT_REFS - 1)) begin
          state_d = ST_WAIT; wcnt_d = W_IREF; ret_d = ST_MRS;
        end
      end
      ST_MRS:  state_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_pend_i)       state_d = ST_REF;
        else if (req_valid_i) state_d = ST_ACT;
      end
      ST_REF: begin state_d = ST_WAIT; wcnt_d = W_REF; ret_d = ST_IDLE; end
      ST_ACT: begin
        state_d = ST_WAIT; wcnt_d = W_ACT; ret_d = lat_we_q ? ST_WR : ST_RD;
      end
      ST_RD:  begin state_d = ST_WAIT; wcnt_d = W_RD;  ret_d = ST_PRE;  end
      ST_WR:  begin state_d = ST_WAIT; wcnt_d = W_WR;  ret_d = ST_PRE;  end
      ST_PRE: begin state_d = ST_WAIT; wcnt_d = W_PRE; ret_d = ST_IDLE; end
      ST_WAIT: begin
        if (wcnt_q == '0) state_d = ret_q;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      ret_q      <= ST_OFF;
      wcnt_q     <= '0;
      iref_q     <= '0;
      done_q     <= 1'b0;
      lat_we_q   <= 1'b0;
      lat_bank_q <= '0;
      lat_row_q  <= '0;
      lat_col_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      wcnt_q  <= wcnt_d;
      iref_q  <= iref_d;
      if (state_q == ST_MRS) done_q <= 1'b1;
      if (accept) begin
        lat_we_q   <= req_we_i;
        lat_bank_q <= req_bank_i;
        lat_row_q  <= req_row_i;
        lat_col_q  <= req_col_i;
      end
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_q)
      ST_IPRE, ST_PRE: begin cmd_o = CMD_PRE; addr_o = AP_MASK; end
      ST_IREF, ST_REF: cmd_o = CMD_REF;
      ST_MRS: begin cmd_o = CMD_MRS; addr_o = MODE_WORD; end
      ST_ACT: begin cmd_o = CMD_ACT; addr_o = lat_row_q; ba_o = lat_bank_q; end
      ST_RD:  begin cmd_o = CMD_RD; addr_o = ROW_W'(lat_col_q); ba_o = lat_bank_q; end
      ST_WR:  begin cmd_o = CMD_WR; addr_o = ROW_W'(lat_col_q); ba_o = lat_bank_q; end
      default: ;
    endcase
  end

  // cycles since the last refresh command, saturating; checker support
  logic [3:0] since_ref_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_ref_q <= 4'hf;
    else if (cmd_o == CMD_REF)  since_ref_q <= 4'h0;
    else if (since_ref_q != 4'hf) since_ref_q <= since_ref_q + 4'h1;
  end

  assert_pre_to_act_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> ($past(cmd_o) != CMD_PRE && $past(cmd_o, 2) != CMD_PRE));

  assert_act_to_col_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> ($past(cmd_o, 2) == CMD_ACT && $past(cmd_o) == CMD_NOP));

  assert_ref_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT || cmd_o == CMD_MRS) |-> (since_ref_q >= 4'(T_RFC_GAP)));

  assert_busy_in_init_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (busy_o && cmd_o != CMD_ACT && cmd_o != CMD_RD && cmd_o != CMD_WR));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 1,
  localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              ref_tick_i,
  output logic [3:0]        cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              busy_o,
  output logic              init_done_o,
  output logic              rd_valid_o,
  output logic              wr_en_o
);
  logic ref_pend, ref_take, rd_issue, wr_issue;
  cmd_e cmd;

  assign cmd_o = cmd;

  sdram_ref_timer #(.RELOAD(REF_RELOAD)) u_ref_timer (
    .clk_i, .rst_ni,
    .en_i   (init_done_o),
    .tick_i (ref_tick_i),
    .take_i (ref_take),
    .pend_o (ref_pend)
  );

  sdram_seq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .req_valid_i, .req_we_i,
    .req_bank_i  (req_addr_i[ADDR_W-1 -: BANK_W]),
    .req_row_i   (req_addr_i[COL_W +: ROW_W]),
    .req_col_i   (req_addr_i[COL_W-1:0]),
    .ref_pend_i  (ref_pend),
    .ref_take_o  (ref_take),
    .init_done_o,
    .busy_o,
    .cmd_o       (cmd),
    .addr_o,
    .ba_o,
    .rd_issue_o  (rd_issue),
    .wr_issue_o  (wr_issue)
  );

  sdram_data_timer #(.CL(CAS_LAT), .BL(BURST_LEN)) u_data_timer (
    .clk_i, .rst_ni,
    .rd_issue_i (rd_issue),
    .wr_issue_i (wr_issue),
    .rd_valid_o,
    .wr_en_o
  );

endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  // {we, bank, row[10:0], col[7:0]}
  localparam int NV = 6;
  localparam logic [NV-1:0][20:0] VEC = {
    21'h000000, 21'h1FFFFF, 21'h0ABCDE, 21'h154321, 21'h1800FF, 21'h07FF00
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, req_valid_i = 1'b0, req_we_i = 1'b0, ref_tick_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [3:0]  cmd_o;
  logic [10:0] addr_o;
  logic [0:0]  ba_o;
  logic busy_o, init_done_o, rd_valid_o, wr_en_o;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_cmd_seq u_sdram_cmd_seq (
    .clk_i(clk), .rst_ni, .start_i, .req_valid_i, .req_we_i, .req_addr_i,
    .ref_tick_i, .cmd_o, .addr_o, .ba_o, .busy_o, .init_done_o,
    .rd_valid_o, .wr_en_o
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic do_access(input logic [20:0] v);
    logic we;
    int off;
    we = v[20];
    off = we ? 5 : 6;
    while (busy_o) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = v[19:0];
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(cmd_o == C_ACT, "R6 act", cmd_o, C_ACT);
    chk(addr_o == v[18:8], "R6 row", addr_o, v[18:8]);
    chk(ba_o == v[19], "R6 bank", ba_o, v[19]);
    chk(busy_o, "R6 busy", busy_o, 1);
    @(negedge clk);
    chk(cmd_o == C_NOP, "R7 gap", cmd_o, C_NOP);
    @(negedge clk);
    chk(cmd_o == (we ? C_WR : C_RD), "R7 col cmd", cmd_o, we ? C_WR : C_RD);
    chk(addr_o == {3'b000, v[7:0]}, "R7 col addr", addr_o, {3'b000, v[7:0]});
    chk(ba_o == v[19], "R7 bank", ba_o, v[19]);
    if (we) chk(wr_en_o, "R10 wr_en first", wr_en_o, 1);
    else    chk(!rd_valid_o, "R8 rd_valid early", rd_valid_o, 0);
    for (int k = 1; k <= off; k++) begin
      @(negedge clk);
      if (we) chk(wr_en_o == (k <= 3), "R10 wr_en", wr_en_o, (k <= 3));
      else    chk(rd_valid_o == (k >= 2 && k <= 5), "R8 rd_valid", rd_valid_o, (k >= 2 && k <= 5));
      if (k < off) chk(cmd_o == C_NOP, we ? "R10 pre wait" : "R9 pre wait", cmd_o, C_NOP);
      else begin
        chk(cmd_o == C_PRE && addr_o[10], we ? "R10 pre" : "R9 pre", {addr_o, cmd_o}, {11'h400, C_PRE});
      end
    end
    @(negedge clk);
    chk(busy_o && cmd_o == C_NOP, "R11 busy after pre", {busy_o, cmd_o}, {1'b1, C_NOP});
    @(negedge clk);
    chk(!busy_o, "R11 idle", busy_o, 0);
  endtask

  function automatic logic [3:0] exp_mix(input int k);
    case (k)
      0, 19:   return C_ACT;
      2:       return C_RD;
      8:       return C_PRE;
      11:      return C_REF;
      default: return C_NOP;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o && !init_done_o && cmd_o == C_NOP, "R1 reset",
        {busy_o, init_done_o, cmd_o}, {1'b1, 1'b0, C_NOP});
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o && cmd_o == C_NOP, "R1 wait start", {busy_o, cmd_o}, {1'b1, C_NOP});
    // request and ticks held during the whole init
    start_i = 1'b1; req_valid_i = 1'b1; req_addr_i = 20'h12345; ref_tick_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(cmd_o == C_PRE, "R2 init pre R14", cmd_o, C_PRE);
    chk(addr_o[10], "R2 pre all", addr_o, 11'h400);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(cmd_o == C_NOP && busy_o, "R3 pre gap", {busy_o, cmd_o}, {1'b1, C_NOP});
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cmd_o == C_REF, "R3 init ref", cmd_o, C_REF);
    end
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk(cmd_o == C_NOP && busy_o && !init_done_o, "R4 ref gap R1",
          {busy_o, init_done_o, cmd_o}, {1'b1, 1'b0, C_NOP});
    end
    @(negedge clk);
    chk(cmd_o == C_MRS, "R4 mode load", cmd_o, C_MRS);
    chk(addr_o == 11'h022, "R4 mode word", addr_o, 11'h022);
    @(negedge clk);
    chk(init_done_o && !busy_o && cmd_o == C_NOP, "R5 done",
        {init_done_o, busy_o, cmd_o}, {1'b1, 1'b0, C_NOP});
    req_valid_i = 1'b0; ref_tick_i = 1'b0;
    @(negedge clk);
    chk(cmd_o == C_NOP && !busy_o, "R1 no request from init", {busy_o, cmd_o}, {1'b0, C_NOP});

    // start after init
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(cmd_o == C_NOP && !busy_o, "R2 start ignored", {busy_o, cmd_o}, {1'b0, C_NOP});
    @(negedge clk);
    chk(cmd_o == C_NOP, "R2 start ignored later", cmd_o, C_NOP);

    for (int i = 0; i < NV; i++) do_access(VEC[i]);

    // idle refresh: 16 ticks after init
    @(negedge clk);
    ref_tick_i = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (i < 16) chk(!busy_o && cmd_o == C_NOP, "R5 R12 no early refresh",
                      {busy_o, cmd_o}, {1'b0, C_NOP});
      else begin
        chk(busy_o && cmd_o == C_NOP, "R12 pending busy", {busy_o, cmd_o}, {1'b1, C_NOP});
        ref_tick_i = 1'b0;
      end
    end
    @(negedge clk);
    chk(cmd_o == C_REF, "R12 refresh from idle", cmd_o, C_REF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(busy_o && cmd_o == C_NOP, "R13 refresh recovery", {busy_o, cmd_o}, {1'b1, C_NOP});
    end
    @(negedge clk);
    chk(!busy_o, "R13 idle after refresh", busy_o, 0);

    // 15 ticks: no refresh yet
    ref_tick_i = 1'b1;
    repeat (15) @(negedge clk);
    ref_tick_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && cmd_o == C_NOP, "R12 fifteen ticks", {busy_o, cmd_o}, {1'b0, C_NOP});

    // 16th tick with a read: refresh waits, then beats the held request
    ref_tick_i = 1'b1; req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = 20'h2468A;
    for (int k = 0; k <= 19; k++) begin
      @(negedge clk);
      chk(cmd_o == exp_mix(k), k == 11 ? "R12 deferred refresh" : "R13 order", cmd_o, exp_mix(k));
      chk(busy_o == (k != 18), "R13 busy", busy_o, (k != 18));
      if (k == 0) ref_tick_i = 1'b0;
      if (k == 19) req_valid_i = 1'b0;
    end
    while (busy_o) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1-scope timeout actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule